// File: doc/BRIEF.md
# IDE Timing Controller Register Bank

This block is the set of registers a host sees in a legacy dual-channel IDE timing controller that sits on an 8-bit I/O bus. It claims a four-byte I/O window. A strap pin places the window at one of two base addresses. The window holds two writable drive-timing words, one read-only byte and one writable control byte. The read-only byte reports the strap pins and a chip-identity nibble. The control byte holds the channel-mode and buffering flags.

The block also acts as a timing router. When a drive access is about to start, the bus-cycle logic presents the channel and drive numbers. The block answers in the same cycle with the 8-bit timing word that applies and a two-bit index that names the timer register supplying it. Which timer serves which drive depends on the primary-only flag in the control byte.

Register reads are combinational from the address and the read strobe. Writes take effect at the next clock edge. The bus is a plain strobe interface with no handshake. Every access completes in a single cycle, so the block never applies back-pressure.

Top module: `ide_timing_regbank`

## Requirements
- R1: The window base is 0xB0 when `strap_win_hi` is 1 and 0x30 when it is 0. `io_hit` is 1 exactly when `io_addr` lies in base..base+3. For any other address, `io_hit` is 0 and `io_rdata` reads 0x00.
- R2: A read at offset 0 returns timer A. A read at offset 2 returns timer B. A read at offset 3 returns the control byte.
- R3: A read at offset 1 returns the configuration byte, laid out as follows:
  - bit 0 = `strap_ide_pri` (1 = primary command block).
  - bit 1 = `strap_win_hi`.
  - bit 2 = `strap_slow_bus` (1 = bus clock of 33 MHz or less).
  - bit 3 = 1.
  - bits 7:4 = `ID_CODE` (default 4'b1010).
- R4: A write to offset 1 changes no register.
- R5: A claimed write to offset 0, 2 or 3 loads `io_wdata` into the register at that offset at the next clock edge. A write to an address outside the window changes no register.
- R6: After reset, both timers hold `RST_TIMING` (default 0x00) and the control byte holds 0x5F.
- R7: When control bit 0 is 1 (primary-only mode), drive 0 gets timer A and drive 1 gets timer B, whatever the value of `acc_chan`.
- R8: When control bit 0 is 0, channel 0 gets timer A and channel 1 gets timer B for both of its drives.
- R9: `tim_index` is {bit 1 of the selected timer's address, bit 7 of the window base}, so timer A gives {0, `strap_win_hi`} and timer B gives {1, `strap_win_hi`}.
- R10: `primary_only` follows control bit 0 and `buf_en` follows control bit 7. Writing 0x5F to the control byte clears `buf_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_win_hi | input | 1 | Window base strap (1 = 0xB0, 0 = 0x30) |
| strap_ide_pri | input | 1 | IDE command-block base strap |
| strap_slow_bus | input | 1 | Bus-speed strap (1 = 33 MHz or less) |
| io_addr | input | 8 | I/O address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (0x00 when not claimed) |
| io_hit | output | 1 | Address claimed by the window |
| acc_chan | input | 1 | Channel of the coming drive access |
| acc_drive | input | 1 | Drive number within the channel |
| tim_word | output | 8 | Timing word for the access |
| tim_index | output | 2 | Index of the timer register supplying it |
| primary_only | output | 1 | Primary-only mode flag |
| buf_en | output | 1 | Read-ahead and post-write buffering enable |

## Verification
The hardest case to reach from the ports is a change of the routing mode while the timers hold distinct values. Only then can a wrong timer assignment be seen. The bench loads timer A and timer B with different patterns, then sweeps all channel and drive combinations under both values of control bit 0, rewriting the control byte between sweeps. It also reads every address under both window straps, so that near-miss addresses from the other window are seen to be unclaimed.

// File: rtl/ide_regbank_pkg.sv
package ide_regbank_pkg;
  localparam int BYTE_W = 8;
  localparam int OFS_W  = 2;
  localparam int N_OFS  = 4;
  localparam logic [OFS_W-1:0] OFS_TIM_A = 2'd0;
  localparam logic [OFS_W-1:0] OFS_CFG   = 2'd1;
  localparam logic [OFS_W-1:0] OFS_TIM_B = 2'd2;
  localparam logic [OFS_W-1:0] OFS_CTRL  = 2'd3;

  typedef struct packed {
    logic [3:0] id;
    logic       one;
    logic       slow_bus;
    logic       win_hi;
    logic       ide_pri;
  } cfg_byte_t;
endpackage

// File: rtl/ide_rb_decode.sv
module ide_rb_decode
  import ide_regbank_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter logic [7:0]  BASE_LO = 8'h30,
  parameter logic [7:0]  BASE_HI = 8'hB0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              win_hi,
  output logic              hit,
  output logic [N_OFS-1:0]  sel
);
  localparam int TAG_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] base;
  assign base = win_hi ? ADDR_W'(BASE_HI) : ADDR_W'(BASE_LO);
  assign hit  = (addr[ADDR_W-1:OFS_W] == base[ADDR_W-1:OFS_W]);

  for (genvar g = 0; g < N_OFS; g++) begin : g_sel
    assign sel[g] = hit && (addr[OFS_W-1:0] == OFS_W'(g));
  end

  // R1
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $countones(sel) == 1);
  // R1
  sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> sel == '0);

  logic [TAG_W-1:0] unused_tag;
  assign unused_tag = base[ADDR_W-1:OFS_W];
endmodule

// File: rtl/ide_rb_regs.sv
module ide_rb_regs
  import ide_regbank_pkg::*;
#(
  parameter logic [3:0] ID_CODE    = 4'b1010,
  parameter logic [7:0] RST_TIMING = 8'h00,
  parameter logic [7:0] RST_CTRL   = 8'h5F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [N_OFS-1:0]  sel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              win_hi,
  input  logic              ide_pri,
  input  logic              slow_bus,
  output logic [BYTE_W-1:0] tim_a,
  output logic [BYTE_W-1:0] tim_b,
  output logic [BYTE_W-1:0] ctrl,
  output logic [BYTE_W-1:0] rdata
);
  cfg_byte_t cfg;
  assign cfg = '{id: ID_CODE, one: 1'b1, slow_bus: slow_bus,
                 win_hi: win_hi, ide_pri: ide_pri};

  logic [BYTE_W-1:0] bank [N_OFS];
  logic [N_OFS-1:0]  wen;

  for (genvar g = 0; g < N_OFS; g++) begin : g_reg
    if (g == int'(OFS_CFG)) begin : g_ro
      assign wen[g]  = 1'b0;
      assign bank[g] = cfg;
    end else begin : g_rw
      localparam logic [BYTE_W-1:0] RV = (g == int'(OFS_CTRL)) ? RST_CTRL : RST_TIMING;
      logic [BYTE_W-1:0] q;
      assign wen[g] = wr && sel[g];
      always_ff @(posedge clk) begin
        if (!rst_n)      q <= RV;
        else if (wen[g]) q <= wdata;
      end
      assign bank[g] = q;
    end
  end

  assign tim_a = bank[OFS_TIM_A];
  assign tim_b = bank[OFS_TIM_B];
  assign ctrl  = bank[OFS_CTRL];

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_OFS; i++)
      if (rd && sel[i]) rdata = bank[i];
  end

  // R5
  tim_a_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel[OFS_TIM_A]) |=> tim_a == $past(wdata));
  // R5
  tim_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && sel[OFS_TIM_A]) |=> $stable(tim_a));
  // R4
  cfg_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel[OFS_CFG]) |=> ($stable(tim_a) && $stable(tim_b) && $stable(ctrl)));
  // R5
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && sel[OFS_CTRL]) |=> $stable(ctrl));
endmodule

// File: rtl/ide_rb_route.sv
module ide_rb_route
  import ide_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] ctrl,
  input  logic [BYTE_W-1:0] tim_a,
  input  logic [BYTE_W-1:0] tim_b,
  input  logic              win_hi,
  input  logic              chan,
  input  logic              drive,
  output logic [BYTE_W-1:0] word,
  output logic [1:0]        index,
  output logic              prim_only,
  output logic              buf_on
);
  logic use_b;
  assign prim_only = ctrl[0];
  assign buf_on    = ctrl[7];
  assign use_b     = prim_only ? drive : chan;
  assign word      = use_b ? tim_b : tim_a;
  assign index     = {use_b, win_hi};

  // R7
  prim_drive0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prim_only && !drive) |-> (word == tim_a && !index[1]));
  // R8
  dual_chan1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!prim_only && chan) |-> (word == tim_b && index[1]));
endmodule

// File: rtl/ide_timing_regbank.sv
module ide_timing_regbank
  import ide_regbank_pkg::*;
#(
  parameter logic [7:0] BASE_LO    = 8'h30,
  parameter logic [7:0] BASE_HI    = 8'hB0,
  parameter logic [3:0] ID_CODE    = 4'b1010,
  parameter logic [7:0] RST_TIMING = 8'h00,
  parameter logic [7:0] RST_CTRL   = 8'h5F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_win_hi,
  input  logic       strap_ide_pri,
  input  logic       strap_slow_bus,
  input  logic [7:0] io_addr,
  input  logic       io_wr,
  input  logic       io_rd,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  output logic       io_hit,
  input  logic       acc_chan,
  input  logic       acc_drive,
  output logic [7:0] tim_word,
  output logic [1:0] tim_index,
  output logic       primary_only,
  output logic       buf_en
);
  logic [N_OFS-1:0]  sel;
  logic [BYTE_W-1:0] tim_a, tim_b, ctrl;

  ide_rb_decode #(.ADDR_W(8), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(io_addr), .win_hi(strap_win_hi),
    .hit(io_hit), .sel(sel));

  ide_rb_regs #(.ID_CODE(ID_CODE), .RST_TIMING(RST_TIMING), .RST_CTRL(RST_CTRL)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(io_wr), .rd(io_rd), .sel(sel), .wdata(io_wdata),
    .win_hi(strap_win_hi), .ide_pri(strap_ide_pri), .slow_bus(strap_slow_bus),
    .tim_a(tim_a), .tim_b(tim_b), .ctrl(ctrl), .rdata(io_rdata));

  ide_rb_route u_route (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .tim_a(tim_a), .tim_b(tim_b),
    .win_hi(strap_win_hi), .chan(acc_chan), .drive(acc_drive),
    .word(tim_word), .index(tim_index), .prim_only(primary_only), .buf_on(buf_en));

  // R1
  unclaimed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_hit |-> io_rdata == 8'h00);
  // R9
  index_strap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tim_index[0] == strap_win_hi);
endmodule

// File: tb/sim_ide_timing_regbank.sv
module sim_ide_timing_regbank;
  logic clk = 1'b0, rst_n = 1'b0;
  logic strap_win_hi = 1'b0, strap_ide_pri = 1'b1, strap_slow_bus = 1'b0;
  logic [7:0] io_addr = '0, io_wdata = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_rdata, tim_word;
  logic io_hit, acc_chan = 1'b0, acc_drive = 1'b0;
  logic [1:0] tim_index;
  logic primary_only, buf_en;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ide_timing_regbank u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d, output logic h);
    @(negedge clk); io_addr = a; io_rd = 1'b1; #1;
    d = io_rdata; h = io_hit;
    io_rd = 1'b0;
  endtask

  function automatic logic [7:0] cfg_exp(logic hi, logic pri, logic slow);
    return {4'b1010, 1'b1, slow, hi, pri};
  endfunction

  task automatic reset_dut();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [7:0] d, base, ta, tb;
    logic h;
    for (int s = 0; s < 2; s++) begin
      strap_win_hi = s[0]; strap_ide_pri = ~s[0]; strap_slow_bus = s[0];
      base = s[0] ? 8'hB0 : 8'h30;
      reset_dut();
      // R6 reset values
      rd(base + 8'd0, d, h); chk("R6 timer A reset", d, 8'h00);
      rd(base + 8'd2, d, h); chk("R6 timer B reset", d, 8'h00);
      rd(base + 8'd3, d, h); chk("R6 ctrl reset", d, 8'h5F);
      chk("R10 buf_en after reset", buf_en, 1'b0);
      chk("R10 primary_only after reset", primary_only, 1'b1);
      // R1/R2/R3 full address sweep
      ta = 8'h11 + 8'(s); tb = 8'hE2 - 8'(s);
      wr(base + 8'd0, ta); wr(base + 8'd2, tb);
      for (int a = 0; a < 256; a++) begin
        logic in_w;
        logic [7:0] exp;
        rd(8'(a), d, h);
        in_w = (8'(a) >= base) && (8'(a) < base + 8'd4);
        chk("R1 claim", h, in_w);
        case (8'(a) - base)
          8'd0: exp = ta;
          8'd1: exp = cfg_exp(s[0], ~s[0], s[0]);
          8'd2: exp = tb;
          8'd3: exp = 8'h5F;
          default: exp = 8'h00;
        endcase
        if (!in_w) exp = 8'h00;
        chk(in_w ? "R2/R3 readback" : "R1 unclaimed data", d, exp);
      end
      // R4 config write ignored
      wr(base + 8'd1, 8'h00);
      rd(base + 8'd1, d, h); chk("R4 cfg unchanged", d, cfg_exp(s[0], ~s[0], s[0]));
      rd(base + 8'd0, d, h); chk("R4 timer A unchanged", d, ta);
      rd(base + 8'd2, d, h); chk("R4 timer B unchanged", d, tb);
      rd(base + 8'd3, d, h); chk("R4 ctrl unchanged", d, 8'h5F);
      // R5 write to other window ignored
      wr(base ^ 8'h80, 8'h77); wr((base ^ 8'h80) + 8'd2, 8'h77);
      rd(base + 8'd0, d, h); chk("R5 foreign write A", d, ta);
      rd(base + 8'd2, d, h); chk("R5 foreign write B", d, tb);
      // R7/R8/R9 routing sweep under both modes
      for (int m = 0; m < 2; m++) begin
        wr(base + 8'd3, m[0] ? 8'hDF : 8'h5E);
        for (int c = 0; c < 2; c++)
          for (int dv = 0; dv < 2; dv++) begin
            logic ub;
            @(negedge clk); acc_chan = c[0]; acc_drive = dv[0]; #1;
            ub = m[0] ? dv[0] : c[0];
            chk(m[0] ? "R7 word" : "R8 word", tim_word, ub ? tb : ta);
            chk("R9 index", tim_index, {ub, s[0]});
          end
        chk("R10 primary_only", primary_only, m[0]);
        chk("R10 buf_en", buf_en, m[0]);
      end
      wr(base + 8'd3, 8'h5F);
      @(negedge clk); #1;
      chk("R10 0x5F clears buf_en", buf_en, 1'b0);
      rd(base + 8'd3, d, h); chk("R5 ctrl write", d, 8'h5F);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule